// File: doc/BRIEF.md
# Two-Channel Double-Buffered DAC Code Holder

This block keeps two code registers for each of two converter channels: a staging buffer that a command decoder writes, and an output register whose value drives the converter. It takes write and update strobes, each with a two-bit channel mask, from the decoder. It also takes two asynchronous active-low pins from the board. A falling edge on the load pin moves the staging buffers into the output registers, but only for the channels that are under pin control. A falling edge on the clear pin forces every register to a fixed clear code.

A two-bit mode mask sets how each channel is updated. A channel with its bit at 0 waits for the load pin. A channel with its bit at 1 ignores the pin and takes new data on the same clock edge as the write. A clear starts a clear mode, shown on a flag output. The mode lasts until the decoder reports that the next serial word has finished. A parameter picks the clear code, which is also the reset code: all zeros, or only the top bit set.

Top module: `dac_dbuf`

## Requirements
- R1: After reset, both output codes read the clear code and `clr_mode` is 0.
- R2: A write (`wr_en` = 1) to a channel whose `sync_mask` bit is 0 changes only that channel's staging buffer. Its output code does not change.
- R3: A write to a channel whose `sync_mask` bit is 1 loads `wr_data` into both its buffer and its output register on that same clock edge.
- R4: A falling edge on `ldac_n` is seen on the third rising clock edge after the pin falls. On that edge every channel whose `sync_mask` bit is 0 copies its buffer to its output. Channels whose bit is 1 are left as they are.
- R5: When a channel's buffer has not been rewritten, a load edge leaves its output unchanged. With no strobe and no pin edge, both outputs hold their values.
- R6: `upd_en` copies the buffer to the output for every channel set in `upd_mask`, whatever that channel's `sync_mask` bit is.
- R7: A falling edge on `clr_n` is seen on the third rising edge after the pin falls. On that edge both buffers and both outputs are set to the clear code and `clr_mode` goes to 1. A write arriving in that same cycle is lost.
- R8: `clr_mode` returns to 0 on the edge after a `word_done` pulse. It stays at 1 until then.
- R9: When a write and a load edge reach the same clock edge, a pin-controlled channel outputs the newly written data.
- R10: The clear code is 16'h0000 when `MID_CLEAR` = 0 and 16'h8000 when `MID_CLEAR` = 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Buffer write strobe from the decoder |
| wr_mask | input | 2 | Channels targeted by the write (bit 0 = A, bit 1 = B) |
| wr_data | input | W | Code to write |
| upd_en | input | 1 | Software update strobe |
| upd_mask | input | 2 | Channels targeted by the update |
| word_done | input | 1 | Pulse when a serial word has finished |
| sync_mask | input | 2 | 1 = channel updates on write, 0 = channel waits for the load pin |
| ldac_n | input | 1 | Asynchronous load pin, acts on its falling edge |
| clr_n | input | 1 | Asynchronous clear pin, acts on its falling edge |
| dac_a | output | W | Output code of channel A |
| dac_b | output | W | Output code of channel B |
| clr_mode | output | 1 | High while clear mode is active |

## Verification
The directed patterns each separate one pair of behaviours. A write with no load edge shows the difference between the buffer and the output. A load pulse with mixed modes shows that only pin-controlled channels react. An update strobe moves a buffer that the pin left alone. A write placed exactly in the load-edge cycle shows which one takes effect first. A clear that lands on a write shows that the clear wins, and a later load pulse shows that the buffers were wiped as well. A random phase then mixes all strobes and short pin pulses, with mode-mask changes and frequent word completions. This covers overlaps that the directed steps do not reach, such as a clear and a word completion in the same cycle. A second instance, set for the top-bit clear code, is checked after reset and after a clear.

// File: rtl/dac_dbuf.sv
module dac_dbuf #(
  parameter int W = 16,
  parameter bit MID_CLEAR = 1'b0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [1:0]   wr_mask,
  input  logic [W-1:0] wr_data,
  input  logic         upd_en,
  input  logic [1:0]   upd_mask,
  input  logic         word_done,
  input  logic [1:0]   sync_mask,
  input  logic         ldac_n,
  input  logic         clr_n,
  output logic [W-1:0] dac_a,
  output logic [W-1:0] dac_b,
  output logic         clr_mode
);
  localparam logic [W-1:0] CLR_CODE = MID_CLEAR ? {1'b1, {(W-1){1'b0}}} : '0;

  logic [2:0] ldac_sh, clr_sh;
  logic ldac_fall, clr_fall;
  logic [W-1:0] buf_q [2];
  logic [W-1:0] dac_q [2];
  logic [W-1:0] buf_nx [2];
  logic [1:0] dac_ld;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ldac_sh <= '1;
      clr_sh  <= '1;
    end else begin
      ldac_sh <= {ldac_sh[1:0], ldac_n};
      clr_sh  <= {clr_sh[1:0], clr_n};
    end
  end

  assign ldac_fall = ldac_sh[2] & ~ldac_sh[1];
  assign clr_fall  = clr_sh[2] & ~clr_sh[1];

  always_comb begin
    for (int i = 0; i < 2; i++) begin
      buf_nx[i] = (wr_en && wr_mask[i]) ? wr_data : buf_q[i];
      dac_ld[i] = (ldac_fall && !sync_mask[i]) || (upd_en && upd_mask[i]) ||
                  (wr_en && wr_mask[i] && sync_mask[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 2; i++) begin
        buf_q[i] <= CLR_CODE;
        dac_q[i] <= CLR_CODE;
      end
      clr_mode <= 1'b0;
    end else if (clr_fall) begin
      for (int i = 0; i < 2; i++) begin
        buf_q[i] <= CLR_CODE;
        dac_q[i] <= CLR_CODE;
      end
      clr_mode <= 1'b1;
    end else begin
      for (int i = 0; i < 2; i++) begin
        buf_q[i] <= buf_nx[i];
        if (dac_ld[i]) dac_q[i] <= buf_nx[i];
      end
      if (word_done) clr_mode <= 1'b0;
    end
  end

  assign dac_a = dac_q[0];
  assign dac_b = dac_q[1];
endmodule

// File: rtl/dac_dbuf_chk.sv
module dac_dbuf_chk #(
  parameter int W = 16,
  parameter bit MID_CLEAR = 1'b0
) (
  input logic         clk,
  input logic         rst_n,
  input logic         wr_en,
  input logic [1:0]   wr_mask,
  input logic [W-1:0] wr_data,
  input logic         upd_en,
  input logic [1:0]   upd_mask,
  input logic         word_done,
  input logic [1:0]   sync_mask,
  input logic         ldac_fall,
  input logic         clr_fall,
  input logic [W-1:0] buf_a,
  input logic [W-1:0] buf_b,
  input logic [W-1:0] dac_a,
  input logic [W-1:0] dac_b,
  input logic         clr_mode
);
  localparam logic [W-1:0] CODE = MID_CLEAR ? {1'b1, {(W-1){1'b0}}} : '0;

  AST_CLR_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    clr_fall |=> (dac_a == CODE && dac_b == CODE && clr_mode)); // R7
  AST_SYNC_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_mask[0] && sync_mask[0] && !clr_fall) |=> dac_a == $past(wr_data)); // R3
  AST_UPD_A: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_mask[0] && !clr_fall && !(wr_en && wr_mask[0])) |=> dac_a == $past(buf_a)); // R6
  AST_UPD_B: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_en && upd_mask[1] && !clr_fall && !(wr_en && wr_mask[1])) |=> dac_b == $past(buf_b)); // R6
  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_fall && !ldac_fall && !upd_en && !wr_en) |=> ($stable(dac_a) && $stable(dac_b))); // R5
  AST_CLR_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (word_done && !clr_fall) |=> !clr_mode); // R8
endmodule

bind dac_dbuf dac_dbuf_chk #(.W(W), .MID_CLEAR(MID_CLEAR)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mask(wr_mask), .wr_data(wr_data),
  .upd_en(upd_en), .upd_mask(upd_mask), .word_done(word_done), .sync_mask(sync_mask),
  .ldac_fall(ldac_fall), .clr_fall(clr_fall), .buf_a(buf_q[0]), .buf_b(buf_q[1]),
  .dac_a(dac_a), .dac_b(dac_b), .clr_mode(clr_mode)
);

// File: tb/sim_dac_dbuf.sv
module sim_dac_dbuf;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic wr_en = 0, upd_en = 0, word_done = 0, ldac_n = 1, clr_n = 1;
  logic [1:0] wr_mask = 0, upd_mask = 0, sync_mask = 0;
  logic [15:0] wr_data = 0;
  logic [15:0] dac_a, dac_b, m_a, m_b;
  logic clr_mode, m_clr;
  int total = 0, bad = 0;
  bit auto_chk = 0, done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  dac_dbuf #(.W(16), .MID_CLEAR(1'b0)) u0 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mask(wr_mask), .wr_data(wr_data),
    .upd_en(upd_en), .upd_mask(upd_mask), .word_done(word_done), .sync_mask(sync_mask),
    .ldac_n(ldac_n), .clr_n(clr_n), .dac_a(dac_a), .dac_b(dac_b), .clr_mode(clr_mode));

  dac_dbuf #(.W(16), .MID_CLEAR(1'b1)) u1 (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_mask(wr_mask), .wr_data(wr_data),
    .upd_en(upd_en), .upd_mask(upd_mask), .word_done(word_done), .sync_mask(sync_mask),
    .ldac_n(ldac_n), .clr_n(clr_n), .dac_a(m_a), .dac_b(m_b), .clr_mode(m_clr));

  // reference model: pin edge acts on the third rising edge after the pin falls
  logic [2:0] pl, pc;
  logic [15:0] mb [2];
  logic [15:0] md [2];
  logic mc;

  function automatic logic [15:0] next_buf(int i, logic [15:0] cur);
    return (wr_en && wr_mask[i]) ? wr_data : cur;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      pl <= '1; pc <= '1; mc <= 0;
      for (int i = 0; i < 2; i++) begin mb[i] <= 0; md[i] <= 0; end
    end else begin
      pl <= {pl[1:0], ldac_n};
      pc <= {pc[1:0], clr_n};
      if (pc[2] && !pc[1]) begin
        for (int i = 0; i < 2; i++) begin mb[i] <= 0; md[i] <= 0; end
        mc <= 1;
      end else begin
        for (int i = 0; i < 2; i++) begin
          mb[i] <= next_buf(i, mb[i]);
          if ((pl[2] && !pl[1] && !sync_mask[i]) || (upd_en && upd_mask[i]) ||
              (wr_en && wr_mask[i] && sync_mask[i]))
            md[i] <= next_buf(i, mb[i]);
        end
        if (word_done) mc <= 0;
      end
    end
  end

  task automatic check(string tag, logic [15:0] act, logic [15:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(logic [1:0] m, logic [15:0] d);
    wr_en = 1; wr_mask = m; wr_data = d;
    tick(1);
    wr_en = 0; wr_mask = 0;
  endtask

  task automatic ldac_pulse();
    ldac_n = 0; tick(1); ldac_n = 1; tick(2);
  endtask

  initial begin
    void'($urandom(32'd7));
    tick(3);
    rst_n = 1;
    tick(1);
    check("R1 dac_a", dac_a, 16'h0000);
    check("R1 dac_b", dac_b, 16'h0000);
    check("R1 clr_mode", {15'd0, clr_mode}, 16'd0);
    check("R10 mid reset", m_a, 16'h8000);

    wr(2'b01, 16'h1234);
    check("R2 buffer only", dac_a, 16'h0000);
    ldac_pulse();
    check("R4 ldac loads A", dac_a, 16'h1234);
    check("R5 B not rewritten", dac_b, 16'h0000);

    sync_mask = 2'b10;
    wr(2'b10, 16'hABCD);
    check("R3 sync write B", dac_b, 16'hABCD);
    wr(2'b01, 16'h5555);
    check("R2 A waits", dac_a, 16'h1234);

    sync_mask = 2'b00;
    wr(2'b10, 16'h2222);
    check("R2 B waits", dac_b, 16'hABCD);
    sync_mask = 2'b10;
    ldac_pulse();
    check("R4 A follows pin", dac_a, 16'h5555);
    check("R4 B ignores pin", dac_b, 16'hABCD);

    upd_en = 1; upd_mask = 2'b10; tick(1); upd_en = 0; upd_mask = 0;
    check("R6 update B", dac_b, 16'h2222);

    sync_mask = 2'b00;
    ldac_n = 0; tick(1); ldac_n = 1; tick(1);
    wr(2'b01, 16'h9999);
    check("R9 write with edge", dac_a, 16'h9999);

    wr(2'b01, 16'h3333);
    clr_n = 0; tick(1); clr_n = 1; tick(1);
    wr(2'b01, 16'h4444);
    check("R7 clear A", dac_a, 16'h0000);
    check("R7 clear B", dac_b, 16'h0000);
    check("R7 clr_mode", {15'd0, clr_mode}, 16'd1);
    check("R10 mid clear", m_b, 16'h8000);
    ldac_pulse();
    check("R7 buffer cleared", dac_a, 16'h0000);
    check("R8 mode held", {15'd0, clr_mode}, 16'd1);
    word_done = 1; tick(1); word_done = 0;
    check("R8 mode exit", {15'd0, clr_mode}, 16'd0);

    auto_chk = 1;
    for (int k = 0; k < 4000; k++) begin
      wr_en = ($urandom % 4) == 0;
      wr_mask = 2'($urandom);
      wr_data = 16'($urandom);
      upd_en = ($urandom % 8) == 0;
      upd_mask = 2'($urandom);
      word_done = ($urandom % 6) == 0;
      if (($urandom % 16) == 0) sync_mask = 2'($urandom);
      ldac_n = ($urandom % 5) != 0;
      clr_n = ($urandom % 40) != 0;
      tick(1);
    end
    auto_chk = 0;
    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(negedge clk) begin
    if (auto_chk) begin
      check("R4 random dac_a", dac_a, md[0]);
      check("R3 random dac_b", dac_b, md[1]);
      check("R8 random clr_mode", {15'd0, clr_mode}, {15'd0, mc});
    end
  end

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=running exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule